// File: doc/BRIEF.md
# Protection Region Configuration Register Bank

This block is a small memory-mapped register file that holds the settings of a set of memory protection regions. A simple single-cycle register bus presents a select, a write flag, a byte offset, write data and a privilege flag. Read data is returned in the same cycle, and a registered error flag pulses one cycle later when an access is refused. The block keeps no access-checking logic of its own. Instead it presents every region's base and attribute word in parallel, together with the global and background enable bits, so that a separate checker can compare addresses against them.

The region settings are reached indirectly. Software places a region index in a number register, and the base and attribute windows then act on that region. Four identical window pairs lead to the same two per-region registers. A base write can also choose the region itself through a valid flag. Reset behaviour differs from field to field. The identification word and the control bits are defined at reset, and so is every region's enable bit. The other region fields and the number register start with arbitrary contents.

Top module: `prot_region_regs`

## Requirements
- R1: Offset 0x00 is read-only and reads 0x00000800, with the region count (8) in bits [15:8]. A privileged write to it pulses `bus_err` in the next cycle and changes nothing.
- R2: Offset 0x04 is the control register and resets to 0. Bit 0 (global enable, output `glob_en`) and bit 2 (background enable, output `bg_en`) are read/write. All other bits read as zero.
- R3: An unprivileged access (`bus_sel`=1, `bus_priv`=0) reads zero, changes no state, and raises `bus_err` for exactly the next cycle.
- R4: Offset 0x08 holds an 8-bit region number in bits [7:0] and reads back what was written. Bits [31:8] read as zero.
- R5: The base window at 0x0C writes bits [31:5] as the base of the region that the number selects. A read returns the stored base in [31:5], 0 in bit 4 and the region number in bits [3:0].
- R6: A base-window write with bit 4 set first loads the region number from bits [3:0], then updates the base of that region.
- R7: The attribute window at 0x10 stores enable in bit 0, size in [5:1], access permission in [26:24] and execute-never in bit 28. All other bits read as zero.
- R8: The window pairs at 0x14/0x18, 0x1C/0x20 and 0x24/0x28 act exactly like 0x0C/0x10 on the same registers.
- R9: When the selected region number is 8 or more, base and attribute writes are ignored and reads of those windows return zero. A bit-4 base write naming region 8 to 15 still loads the number.
- R10: Reset clears the enable bit of every region.
- R11: `rgn_base_o` and `rgn_attr_o` present every region's base word (low 5 bits zero) and masked attribute word, region i at bits [32i+31:32i]. `rgn_en_o` holds the enable bits. All of them update in the cycle after the write.
- R12: Offsets above 0x28, and offsets whose two low bits are not zero, read as zero, ignore writes and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access present this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | Access is privileged |
| bus_addr | input | ADDR_W | Byte offset from block base |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| bus_err | output | 1 | Refused-access pulse, one cycle after the access |
| glob_en | output | 1 | Control bit 0 |
| bg_en | output | 1 | Control bit 2 |
| rgn_en_o | output | NUM_REGIONS | Enable bit per region |
| rgn_base_o | output | 32*NUM_REGIONS | Base words of all regions |
| rgn_attr_o | output | 32*NUM_REGIONS | Attribute words of all regions |

## Verification
The bench builds the block with its defaults, NUM_REGIONS = 8 and ADDR_W = 8. At that size every region can be visited through every one of the four window pairs, with each write read back through a different pair. Every value of the 4-bit field in a bit-4 base write can be tried, and half of those values land out of range. The full 256-value range of the number register and every offset up to 0x3C are also within reach.

// File: rtl/prot_regs_pkg.sv
package prot_regs_pkg;

  localparam logic [31:0] ATTR_KEEP = 32'h1700_003F;
  localparam logic [31:0] CTRL_KEEP = 32'h0000_0005;

  typedef enum logic [2:0] {
    WIN_TYPE,
    WIN_CTRL,
    WIN_NUM,
    WIN_BASE,
    WIN_ATTR,
    WIN_NONE
  } win_e;

  // word index -> window; base/attr pairs alternate from word 3 to word 10
  function automatic win_e win_of(input int unsigned w);
    if (w == 0) return WIN_TYPE;
    if (w == 1) return WIN_CTRL;
    if (w == 2) return WIN_NUM;
    if (w >= 3 && w <= 10) return (w[0]) ? WIN_BASE : WIN_ATTR;
    return WIN_NONE;
  endfunction

  function automatic logic [31:0] type_word(input int unsigned n);
    return {16'h0000, 8'(n), 8'h00};
  endfunction

  function automatic logic [31:0] base_word(input logic [26:0] base, input logic [3:0] fld);
    return {base, 1'b0, fld};
  endfunction

  function automatic logic [31:0] attr_word(input logic en, input logic [4:0] size,
                                            input logic [2:0] ap, input logic xn);
    return {3'b000, xn, 1'b0, ap, 18'h0, size, en};
  endfunction

endpackage

// File: rtl/prot_bus_decode.sv
module prot_bus_decode
  import prot_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              sel,
  input  logic              wr,
  input  logic              priv,
  input  logic [ADDR_W-1:0] addr,
  output win_e              win,
  output logic              acc_ok,
  output logic              err_req
);

  logic [ADDR_W-3:0] word_idx;
  logic              aligned;
  logic              ro_hit;

  assign word_idx = addr[ADDR_W-1:2];
  assign aligned  = (addr[1:0] == 2'b00);

  always_comb begin
    win = WIN_NONE;
    if (aligned) win = win_of(int'(word_idx));
  end

  assign ro_hit  = wr && (win == WIN_TYPE);
  assign err_req = sel && (!priv || ro_hit);
  assign acc_ok  = sel && priv && !ro_hit;

endmodule

// File: rtl/prot_region_bank.sv
module prot_region_bank
  import prot_regs_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  localparam int unsigned IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_base,
  input  logic                      wr_attr,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [31:0]               wdata,
  input  logic [IDX_W-1:0]          rd_idx,
  output logic [26:0]               rd_base,
  output logic [31:0]               rd_attr,
  output logic [NUM_REGIONS-1:0]    en_vec,
  output logic [32*NUM_REGIONS-1:0] base_flat,
  output logic [32*NUM_REGIONS-1:0] attr_flat
);

  logic [26:0] base_q [NUM_REGIONS];
  logic [31:0] attr_w [NUM_REGIONS];

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rgn
    logic       hit;
    logic       en_q;
    logic [4:0] size_q;
    logic [2:0] ap_q;
    logic       xn_q;

    assign hit = (wr_idx == IDX_W'(g));

    // enable has a defined reset
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              en_q <= 1'b0;
      else if (wr_attr && hit) en_q <= wdata[0];
    end

    // remaining fields carry no reset
    always_ff @(posedge clk) begin
      if (wr_attr && hit) begin
        size_q <= wdata[5:1];
        ap_q   <= wdata[26:24];
        xn_q   <= wdata[28];
      end
      if (wr_base && hit) base_q[g] <= wdata[31:5];
    end

    assign attr_w[g]             = attr_word(en_q, size_q, ap_q, xn_q);
    assign en_vec[g]             = en_q;
    assign base_flat[32*g +: 32] = {base_q[g], 5'b00000};
    assign attr_flat[32*g +: 32] = attr_w[g];
  end

  assign rd_base = base_q[rd_idx];
  assign rd_attr = attr_w[rd_idx];

endmodule

// File: rtl/prot_region_regs.sv
module prot_region_regs
  import prot_regs_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned ADDR_W      = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_sel,
  input  logic                      bus_wr,
  input  logic                      bus_priv,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  output logic                      bus_err,
  output logic                      glob_en,
  output logic                      bg_en,
  output logic [NUM_REGIONS-1:0]    rgn_en_o,
  output logic [32*NUM_REGIONS-1:0] rgn_base_o,
  output logic [32*NUM_REGIONS-1:0] rgn_attr_o
);

  localparam int unsigned IDX_W    = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
  localparam logic [7:0]  NR_LIMIT = 8'(NUM_REGIONS);
  localparam logic [31:0] TYPE_VAL = type_word(NUM_REGIONS);

  win_e        win;
  logic        acc_ok;
  logic        err_req;
  logic        wr_ok;
  logic        rd_ok;
  logic [7:0]  num_q;
  logic        glob_q;
  logic        bg_q;
  logic        err_q;

  // named events for the checker
  logic        num_in_range;
  logic        base_wr_req;
  logic        attr_wr_req;
  logic        valid_sel;
  logic [7:0]  tgt_num;
  logic        tgt_in_range;
  logic        base_wr_ev;
  logic        attr_wr_ev;
  logic        num_wr_ev;
  logic        ctrl_wr_ev;
  logic [IDX_W-1:0] wr_idx;
  logic [26:0] rd_base;
  logic [31:0] rd_attr;

  prot_bus_decode #(.ADDR_W(ADDR_W)) dec_i (
    .sel     (bus_sel),
    .wr      (bus_wr),
    .priv    (bus_priv),
    .addr    (bus_addr),
    .win     (win),
    .acc_ok  (acc_ok),
    .err_req (err_req)
  );

  assign wr_ok = acc_ok && bus_wr;
  assign rd_ok = acc_ok && !bus_wr;

  assign num_in_range = (num_q < NR_LIMIT);
  assign base_wr_req  = wr_ok && (win == WIN_BASE);
  assign attr_wr_req  = wr_ok && (win == WIN_ATTR);
  assign valid_sel    = base_wr_req && bus_wdata[4];
  assign tgt_num      = valid_sel ? {4'h0, bus_wdata[3:0]} : num_q;
  assign tgt_in_range = (tgt_num < NR_LIMIT);
  assign base_wr_ev   = base_wr_req && tgt_in_range;
  assign attr_wr_ev   = attr_wr_req && num_in_range;
  assign num_wr_ev    = (wr_ok && (win == WIN_NUM)) || valid_sel;
  assign ctrl_wr_ev   = wr_ok && (win == WIN_CTRL);
  assign wr_idx       = tgt_num[IDX_W-1:0];

  // region number: no defined reset
  always_ff @(posedge clk) begin
    if (num_wr_ev) num_q <= valid_sel ? {4'h0, bus_wdata[3:0]} : bus_wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_q <= 1'b0;
      bg_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q <= err_req;
      if (ctrl_wr_ev) begin
        glob_q <= bus_wdata[0];
        bg_q   <= bus_wdata[2];
      end
    end
  end

  prot_region_bank #(.NUM_REGIONS(NUM_REGIONS)) bank_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_base   (base_wr_ev),
    .wr_attr   (attr_wr_ev),
    .wr_idx    (wr_idx),
    .wdata     (bus_wdata),
    .rd_idx    (num_q[IDX_W-1:0]),
    .rd_base   (rd_base),
    .rd_attr   (rd_attr),
    .en_vec    (rgn_en_o),
    .base_flat (rgn_base_o),
    .attr_flat (rgn_attr_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_ok) begin
      unique case (win)
        WIN_TYPE: bus_rdata = TYPE_VAL;
        WIN_CTRL: bus_rdata = {29'h0, bg_q, 1'b0, glob_q} & CTRL_KEEP;
        WIN_NUM:  bus_rdata = {24'h0, num_q};
        WIN_BASE: bus_rdata = num_in_range ? base_word(rd_base, num_q[3:0]) : '0;
        WIN_ATTR: bus_rdata = num_in_range ? (rd_attr & ATTR_KEEP) : '0;
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign bus_err = err_q;
  assign glob_en = glob_q;
  assign bg_en   = bg_q;

endmodule

// File: rtl/prot_region_regs_chk.sv
module prot_region_regs_chk #(
  parameter int unsigned NUM_REGIONS = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_sel,
  input logic                      bus_priv,
  input logic [31:0]               bus_rdata,
  input logic                      bus_err,
  input logic                      glob_en,
  input logic                      bg_en,
  input logic [NUM_REGIONS-1:0]    rgn_en_o,
  input logic [32*NUM_REGIONS-1:0] rgn_base_o,
  input logic [32*NUM_REGIONS-1:0] rgn_attr_o,
  input logic                      base_wr_req,
  input logic                      tgt_in_range,
  input logic                      attr_wr_req,
  input logic                      num_in_range
);

  assert_unpriv_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_priv) |=> bus_err);

  assert_unpriv_rdata_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_priv) |-> (bus_rdata == 32'h0));

  assert_unpriv_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_priv) |=> ($stable(glob_en) && $stable(bg_en) &&
                                $stable(rgn_base_o) && $stable(rgn_attr_o)));

  assert_err_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> !bus_err);

  assert_oor_base_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (base_wr_req && !tgt_in_range) |=> $stable(rgn_base_o));

  assert_oor_attr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (attr_wr_req && !num_in_range) |=> ($stable(rgn_attr_o) && $stable(rgn_en_o)));

  assert_reset_en_R10: assert property (@(posedge clk)
    !rst_n |=> (rgn_en_o == '0));

endmodule

bind prot_region_regs prot_region_regs_chk #(.NUM_REGIONS(NUM_REGIONS)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_sel      (bus_sel),
  .bus_priv     (bus_priv),
  .bus_rdata    (bus_rdata),
  .bus_err      (bus_err),
  .glob_en      (glob_en),
  .bg_en        (bg_en),
  .rgn_en_o     (rgn_en_o),
  .rgn_base_o   (rgn_base_o),
  .rgn_attr_o   (rgn_attr_o),
  .base_wr_req  (base_wr_req),
  .tgt_in_range (tgt_in_range),
  .attr_wr_req  (attr_wr_req),
  .num_in_range (num_in_range)
);

// File: tb/prot_region_regs_tb_top.sv
`timescale 1ns/1ps
module prot_region_regs_tb_top;

  localparam int NR = 8;
  localparam logic [31:0] AMASK = 32'h1700_003F;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic          bus_priv = 1'b1;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          bus_err;
  logic          glob_en;
  logic          bg_en;
  logic [NR-1:0] rgn_en_o;
  logic [32*NR-1:0] rgn_base_o;
  logic [32*NR-1:0] rgn_attr_o;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  logic [26:0] m_base [NR];
  logic [31:0] m_attr [NR];

  always #2 clk = ~clk;

  prot_region_regs #(.NUM_REGIONS(NR), .ADDR_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_priv(bus_priv), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .glob_en(glob_en),
    .bg_en(bg_en), .rgn_en_o(rgn_en_o), .rgn_base_o(rgn_base_o),
    .rgn_attr_o(rgn_attr_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [7:0] a, input logic [31:0] d,
                     input logic p, output logic [31:0] rd, output logic er);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d; bus_priv = p;
    #1 rd = bus_rdata;
    @(negedge clk);
    er = bus_err;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_priv = 1'b1;
  endtask

  function automatic logic [31:0] pat(input int r, input int a);
    return 32'h9E37_79B9 * (r * 4 + a + 1) ^ (32'(r) << 11);
  endfunction

  task automatic check_outs(input string req);
    for (int r = 0; r < NR; r++) begin
      chk(req, rgn_base_o[32*r +: 32], {m_base[r], 5'b0});
      chk(req, rgn_attr_o[32*r +: 32], m_attr[r]);
      chk(req, {31'b0, rgn_en_o[r]}, {31'b0, m_attr[r][0]});
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic er;
    repeat (3) @(negedge clk);
    // R10, R2: reset state
    chk("R10", {24'b0, rgn_en_o}, 32'h0);
    chk("R2", {30'b0, bg_en, glob_en}, 32'h0);
    rst_n = 1'b1;
    acc(0, 8'h00, 0, 1, rd, er); chk("R1", rd, 32'h0000_0800);
    acc(0, 8'h04, 0, 1, rd, er); chk("R2", rd, 32'h0);

    // R2: control bits
    acc(1, 8'h04, 32'hFFFF_FFFF, 1, rd, er); chk("R2 err", {31'b0, er}, 0);
    acc(0, 8'h04, 0, 1, rd, er); chk("R2", rd, 32'h5);
    chk("R2 out", {30'b0, bg_en, glob_en}, 32'h3);
    acc(1, 8'h04, 32'h0000_0004, 1, rd, er);
    chk("R2 out", {30'b0, bg_en, glob_en}, 32'h2);

    // R1: write to identification word
    acc(1, 8'h00, 32'h1234_5678, 1, rd, er); chk("R1 err", {31'b0, er}, 1);
    acc(0, 8'h00, 0, 1, rd, er); chk("R1", rd, 32'h0000_0800);
    chk("R1 err clear", {31'b0, er}, 0);

    // R4: number register, full range
    for (int v = 0; v < 256; v++) begin
      acc(1, 8'h08, {24'hABCDEF, 8'(v)}, 1, rd, er);
      acc(0, 8'h08, 0, 1, rd, er); chk("R4", rd, 32'(v));
    end

    // R5, R7, R8: every region through every window pair
    for (int r = 0; r < NR; r++) begin
      for (int a = 0; a < 4; a++) begin
        int b = (a + 1) % 4;
        logic [31:0] p = pat(r, a);
        acc(1, 8'h08, 32'(r), 1, rd, er);
        acc(1, 8'(8'h0C + 8 * a), p & 32'hFFFF_FFEF, 1, rd, er);
        m_base[r] = p[31:5];
        acc(0, 8'(8'h0C + 8 * b), 0, 1, rd, er);
        chk("R5 R8 base", rd, {p[31:5], 1'b0, 4'(r)});
        acc(1, 8'(8'h10 + 8 * a), ~p, 1, rd, er);
        m_attr[r] = ~p & AMASK;
        acc(0, 8'(8'h10 + 8 * b), 0, 1, rd, er);
        chk("R7 R8 attr", rd, ~p & AMASK);
      end
    end
    check_outs("R11");

    // R6, R9: bit-4 base writes over every field value
    for (int v = 0; v < 16; v++) begin
      logic [31:0] p = pat(v, 7);
      acc(1, 8'h08, 32'h3, 1, rd, er);
      acc(1, 8'h1C, {p[31:5], 1'b1, 4'(v)}, 1, rd, er);
      acc(0, 8'h08, 0, 1, rd, er); chk("R6 num", rd, 32'(v));
      if (v < NR) begin
        m_base[v] = p[31:5];
        acc(0, 8'h0C, 0, 1, rd, er); chk("R6 base", rd, {p[31:5], 1'b0, 4'(v)});
      end else begin
        acc(0, 8'h0C, 0, 1, rd, er); chk("R9 base read", rd, 32'h0);
        acc(0, 8'h28, 0, 1, rd, er); chk("R9 attr read", rd, 32'h0);
      end
      check_outs("R6 R9 outs");
    end

    // R9: out-of-range number, plain writes
    acc(1, 8'h08, 32'd200, 1, rd, er);
    acc(1, 8'h10, 32'hFFFF_FFFF, 1, rd, er);
    acc(1, 8'h0C, 32'hFFFF_FFE0, 1, rd, er);
    acc(0, 8'h18, 0, 1, rd, er); chk("R9", rd, 32'h0);
    check_outs("R9 outs");

    // R3: unprivileged accesses
    acc(1, 8'h04, 32'h1, 0, rd, er); chk("R3 err", {31'b0, er}, 1);
    chk("R3 ctrl", {30'b0, bg_en, glob_en}, 32'h2);
    acc(1, 8'h08, 32'h1, 1, rd, er); chk("R3 err one cycle", {31'b0, er}, 0);
    acc(1, 8'h10, 32'hFFFF_FFFF, 0, rd, er); chk("R3 err", {31'b0, er}, 1);
    check_outs("R3 outs");
    acc(0, 8'h00, 0, 0, rd, er); chk("R3 rdata", rd, 32'h0);
    chk("R3 err", {31'b0, er}, 1);

    // R12: unmapped and misaligned offsets
    for (int o = 8'h2C; o <= 8'h3C; o += 4) begin
      acc(1, 8'(o), 32'hFFFF_FFFF, 1, rd, er); chk("R12 err", {31'b0, er}, 0);
      acc(0, 8'(o), 0, 1, rd, er); chk("R12 read", rd, 32'h0);
    end
    acc(1, 8'h05, 32'hFFFF_FFFF, 1, rd, er); chk("R12 err", {31'b0, er}, 0);
    acc(0, 8'h06, 0, 1, rd, er); chk("R12 read", rd, 32'h0);
    chk("R12 ctrl", {30'b0, bg_en, glob_en}, 32'h2);
    check_outs("R12 outs");

    // R10: reset again clears every enable
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R10", {24'b0, rgn_en_o}, 32'h0);
    chk("R2 reset", {30'b0, bg_en, glob_en}, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule